// File: doc/BRIEF.md
# Indirect Post-Increment Store Sequencer

This block carries out a single accumulator-to-memory move whose target address is held in RAM rather than in a register. It is handed a two-byte instruction (an opcode byte and an operand byte naming the RAM cell that holds the pointer) together with the accumulator value. It then drives a single-port synchronous byte RAM through a fixed three-step sequence. First it reads the pointer. Next it writes the accumulator to the cell the pointer names. Last it writes the pointer, advanced by one, back to its own cell.

The surrounding core asserts `start_i` for one cycle with the opcode, operand and accumulator on their inputs. The block stays busy for four cycles and raises `done_o` during its last cycle. The RAM returns read data one cycle after the address is presented. The asynchronous reset is released synchronously inside the block. No flags are produced or changed.

Top module: `ipi_store_seq`

## Requirements
- R1: While reset is applied and after it is released, `busy_o`, `done_o` and `ram_we_o` are 0 until a sequence is accepted.
- R2: A `start_i` seen at a clock edge while idle with `opcode_i` = 8'h3F is accepted. In the next cycle `busy_o` is 1, `ram_we_o` is 0 and `ram_addr_o` equals the accepted operand (pointer read).
- R3: The third busy cycle is a write (`ram_we_o` = 1) of the accepted accumulator to the address equal to the byte read from the operand cell.
- R4: The fourth busy cycle writes the pointer plus one to the operand address. `done_o` is 1 for exactly that one cycle, and `busy_o` is 0 in the following cycle.
- R5: The pointer increment wraps modulo 256: a pointer of 8'hFF is written back as 8'h00.
- R6: When the pointer equals the operand address, the store happens first and the write-back then overwrites that cell, leaving it at the old pointer plus one.
- R7: The accumulator is captured when the start is accepted. Changes on `acc_i` while busy do not alter the stored byte.
- R8: A `start_i` while `busy_o` is 1 is ignored. No second sequence follows and no further RAM write occurs.
- R9: A `start_i` with any opcode other than 8'h3F is ignored. `busy_o` stays 0 and no RAM write occurs.
- R10: `ram_we_o` is 1 only in the store and write-back cycles of a sequence, and never while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to run one instruction |
| opcode_i | input | 8 | Opcode byte; only 8'h3F is executed |
| operand_i | input | 8 | Address of the RAM cell holding the pointer |
| acc_i | input | 8 | Accumulator value to store |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | 8 | RAM read data, valid one cycle after the address |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | High during the final (write-back) cycle |

## Verification
The bench focuses on three corner cases. The first is a pointer of 8'hFF: a design with the wrong increment width or missing wrap would write back 8'h100 truncated wrongly or leave the value stuck. The second is a pointer that names its own cell: a design that swapped the store and write-back order would leave the accumulator there instead of the incremented pointer. The third is a changing accumulator and stray starts during a busy sequence: a design that did not latch the accumulator would store the late value, and one that accepted a new start would run a second sequence or write the wrong cell. Random operands, pointers, accumulators and occasional foreign opcodes are checked against a bench memory model, both at the RAM ports cycle by cycle and in final memory contents.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OPC_PTR_STORE = 8'h3F;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_READ  = 3'd1,
    SEQ_CAPT  = 3'd2,
    SEQ_STORE = 3'd3,
    SEQ_WBACK = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int unsigned OPC_W = BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  output seq_state_e       state_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == SEQ_IDLE) && (opcode_i == OPC_PTR_STORE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (accept_o) state_d = SEQ_READ;
      SEQ_READ:  state_d = SEQ_CAPT;
      SEQ_CAPT:  state_d = SEQ_STORE;
      SEQ_STORE: state_d = SEQ_WBACK;
      SEQ_WBACK: state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = (state_q == SEQ_WBACK);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R4
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R8
  AST_FOREIGN_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && opcode_i != OPC_PTR_STORE) |=> !busy_o); // R9
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  seq_state_e   state_i,
  input  logic         accept_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] rdata_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] opd_o,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] ptr_inc_o
);
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] opd_q, opd_d;
  logic [W-1:0] ptr_q, ptr_d;
  logic         ptr_en;

  assign ptr_en = (state_i == SEQ_CAPT);

  always_comb begin
    acc_d = acc_q;
    opd_d = opd_q;
    ptr_d = ptr_q;
    if (accept_i) begin
      acc_d = acc_i;
      opd_d = operand_i;
    end
    if (ptr_en) ptr_d = rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      opd_q <= '0;
      ptr_q <= '0;
    end else begin
      acc_q <= acc_d;
      opd_q <= opd_d;
      ptr_q <= ptr_d;
    end
  end

  // Increment truncates to W bits, so the all-ones pointer wraps to zero.
  assign ptr_inc_o = W'(ptr_q + 1'b1);
  assign acc_o     = acc_q;
  assign opd_o     = opd_q;
  assign ptr_o     = ptr_q;

  AST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != SEQ_IDLE && state_i != SEQ_READ) |-> $stable(acc_q)); // R7
  AST_OPD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != SEQ_IDLE && state_i != SEQ_READ) |-> $stable(opd_q)); // R8
endmodule

// File: rtl/ipi_ram_port.sv
module ipi_ram_port
  import ipi_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  seq_state_e   state_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  logic [W-1:0] ptr_i,
  input  logic [W-1:0] ptr_inc_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wdata_o,
  output logic         we_o
);
  always_comb begin
    addr_o  = opd_i;
    wdata_o = '0;
    we_o    = 1'b0;
    unique case (state_i)
      SEQ_STORE: begin
        addr_o  = ptr_i;
        wdata_o = acc_i;
        we_o    = 1'b1;
      end
      SEQ_WBACK: begin
        addr_o  = opd_i;
        wdata_o = ptr_inc_i;
        we_o    = 1'b1;
      end
      default: begin
        addr_o  = opd_i;
        wdata_o = '0;
        we_o    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ipi_store_seq.sv
module ipi_store_seq
  import ipi_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [7:0]   opcode_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] ram_addr_o,
  output logic [W-1:0] ram_wdata_o,
  output logic         ram_we_o,
  input  logic [W-1:0] ram_rdata_i,
  output logic         busy_o,
  output logic         done_o
);
  logic         rst_int_n;
  seq_state_e   state;
  logic         accept;
  logic [W-1:0] acc_q, opd_q, ptr_q, ptr_inc;

  ipi_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  ipi_ctrl #(.OPC_W(8)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .state_o  (state),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  ipi_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state_i   (state),
    .accept_i  (accept),
    .operand_i (operand_i),
    .acc_i     (acc_i),
    .rdata_i   (ram_rdata_i),
    .acc_o     (acc_q),
    .opd_o     (opd_q),
    .ptr_o     (ptr_q),
    .ptr_inc_o (ptr_inc)
  );

  ipi_ram_port #(.W(W)) u_port (
    .state_i   (state),
    .acc_i     (acc_q),
    .opd_i     (opd_q),
    .ptr_i     (ptr_q),
    .ptr_inc_i (ptr_inc),
    .addr_o    (ram_addr_o),
    .wdata_o   (ram_wdata_o),
    .we_o      (ram_we_o)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_int_n |=> !busy_o); // R1
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    ram_we_o |-> busy_o); // R10
  AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_o) |-> (!ram_we_o && ram_addr_o == $past(operand_i))); // R2
  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ram_we_o && !done_o) |-> (ram_addr_o == $past(ram_rdata_i))); // R3
  AST_WBACK_DATA: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (ram_we_o && ram_wdata_o == W'($past(ram_rdata_i, 2) + 1'b1))); // R5
endmodule

// File: tb/ipi_store_seq_tb.sv
`timescale 1ns/1ps
module ipi_store_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] opcode, operand, acc;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;
  logic       ram_we, busy, done;

  logic [7:0] mem [256];
  logic [7:0] model [256];
  int checks;
  int fails;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  ipi_store_seq dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start), .opcode_i (opcode),
    .operand_i (operand), .acc_i (acc), .ram_addr_o (ram_addr),
    .ram_wdata_o (ram_wdata), .ram_we_o (ram_we), .ram_rdata_i (ram_rdata),
    .busy_o (busy), .done_o (done)
  );

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  function automatic logic [7:0] next_ptr(input logic [7:0] p);
    return 8'(p + 8'd1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One legal instruction with optional disturbance during busy.
  task automatic run_op(input logic [7:0] opd, input logic [7:0] a, input bit disturb);
    logic [7:0] p;
    p = model[opd];
    start = 1'b1; opcode = 8'h3F; operand = opd; acc = a;
    step();
    // cycle 1: pointer read
    if (disturb) begin
      start = 1'b1; operand = ~opd; acc = ~a;
    end else begin
      start = 1'b0;
    end
    check(busy && !ram_we && ram_addr == opd, "R2", ram_addr, opd);
    step();
    check(!ram_we && busy, "R10", ram_we, 0);
    step();
    start = 1'b0;
    check(ram_we && ram_addr == p, "R3 addr", ram_addr, p);
    check(ram_wdata == a, "R7 data", ram_wdata, a);
    check(!done, "R4 early done", done, 0);
    step();
    check(ram_we && done && ram_addr == opd, "R4 wb addr", ram_addr, opd);
    check(ram_wdata == next_ptr(p), "R5 wb data", ram_wdata, next_ptr(p));
    step();
    check(!busy && !done && !ram_we, "R8 end", {busy, done, ram_we}, 0);
    model[p] = a;
    model[opd] = next_ptr(p);
    check(mem[p] == model[p], "R6 target", mem[p], model[p]);
    check(mem[opd] == model[opd], "R6 pointer", mem[opd], model[opd]);
    if (disturb) begin
      check(mem[~opd] == model[~opd], "R8 stray cell", mem[~opd], model[~opd]);
    end
  endtask

  task automatic foreign_op(input logic [7:0] opc, input logic [7:0] opd);
    start = 1'b1; opcode = opc; operand = opd; acc = 8'h5A;
    step();
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(!busy && !ram_we && !done, "R9", {busy, ram_we, done}, 0);
      step();
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 37 + 11);
      model[i] = 8'(i * 37 + 11);
    end
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; operand = 8'h00; acc = 8'h00;
    step(); step();
    check(!busy && !done && !ram_we, "R1 in reset", {busy, done, ram_we}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    check(!busy && !done && !ram_we, "R1 after reset", {busy, done, ram_we}, 0);

    // R5: pointer of FFh wraps
    mem[8'h10] = 8'hFF; model[8'h10] = 8'hFF;
    run_op(8'h10, 8'hC3, 1'b0);
    check(mem[8'h10] == 8'h00, "R5 wrap", mem[8'h10], 0);
    // R6: pointer names its own cell
    mem[8'h08] = 8'h08; model[8'h08] = 8'h08;
    run_op(8'h08, 8'h77, 1'b0);
    check(mem[8'h08] == 8'h09, "R6 self", mem[8'h08], 9);
    // R7 and R8: disturbance while busy
    run_op(8'h20, 8'hA5, 1'b1);
    // R9: foreign opcodes
    foreign_op(8'h3E, 8'h30);
    foreign_op(8'hBF, 8'h31);

    for (int n = 0; n < 60; n++) begin
      logic [7:0] o, a;
      o = 8'($urandom);
      a = 8'($urandom);
      if (($urandom % 8) == 0) foreign_op(8'($urandom) | 8'h40, o);
      else run_op(o, a, ($urandom % 4) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule